// File: doc/BRIEF.md
# Keyed Window Watchdog

This block is a windowed watchdog timer with a small register bus. While it is unarmed, software sets a 12-bit reload value, a window code and a reaction code. It then arms the timer by writing a 32-bit arming key. From then on a down-counter runs from the reload value shifted left by a fixed amount. Software keeps the system alive by writing two 16-bit service words, in a fixed order, to the key register. A service counts only while the counter sits in the permitted part of its period.

Three things count as a violation: the counter reaching zero, a complete service sequence that arrives while the window is shut, and a wrong key word. Any of them sets a sticky status bit. It also fires a one-clock pulse on either the interrupt output or the reset output, as chosen by the reaction code. The timer stays armed after a violation, and the only way to disarm it is a hardware reset. The bus has byte addresses, one write strobe and a combinational read port. Software can read the live counter value to decide when to service.

Top module: `keyed_window_wdog`

## Requirements
- R1: After reset the block is unarmed. The control register (0x90) reads 0, the counter (0xA0) reads 0, status (0x98) reads 0, the reload register (0x94) reads 0xFFF, the reaction register (0xA4) reads 0x5, the window register (0xA8) reads 0x00, and both pulse outputs are low.
- R2: Writing exactly 0xA98559DA to 0x90 arms the block, and 0x90 then reads 0xA98559DA. Writing any other value to 0x90 leaves the block unarmed, and 0x90 keeps reading 0.
- R3: The arming write loads the counter with the reload value shifted left by PRELOAD_SHIFT. After that the counter drops by one on every clock, and its value is readable at 0xA0.
- R4: While armed, writes to 0x90, 0x94, 0xA4 and 0xA8 have no effect. Only a hardware reset disarms the block.
- R5: Writing 0x0000E51A and then 0x0000A35C to 0x9C while the window is open reloads the counter from the scaled reload value, with no violation.
- R6: Window code 0x50 opens the window only while the counter is below half of the scaled reload value. Any other window code keeps the window open for the whole period. A complete sequence that arrives while the window is shut sets status bit 1, fires a violation pulse and leaves the counter running without a reload.
- R7: A key word other than the expected next word sets status bit 2 and fires a violation pulse. After it the sequence starts again, expecting 0xE51A first.
- R8: If the counter is at zero while armed, status bit 0 is set, a violation pulse fires, and the counter reloads from the scaled reload value at the same edge.
- R9: A violation drives a pulse in the clock cycle after the edge that detects it, and the pulse lasts one clock. Reaction code 0xA routes the pulse to nmiPulse; code 0x5, or any code other than 0xA, routes it to resetPulse. The block stays armed afterwards.
- R10: The status bits (0 expiry, 1 window, 2 key) are sticky. Writing 1 to a bit at 0x98 clears it, and writing 0 leaves it unchanged.
- R11: Writes to 0x9C while the block is unarmed are ignored. They set no status bit and fire no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; the only way to disarm |
| busAddr | input | 8 | Byte address of the register access |
| busWData | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one access per clock |
| busRData | output | 32 | Read data for busAddr, combinational |
| nmiPulse | output | 1 | One-clock interrupt pulse on a violation (reaction code 0xA) |
| resetPulse | output | 1 | One-clock reset pulse on a violation (any other reaction code) |

## Verification
The hardest case to reach from the ports is a service sequence whose second word lands just on either side of the half-period boundary. That outcome depends on the counter value at one particular edge, and the counter never stops moving. The stimulus reads the counter in the cycle just before it writes the second key word, which tells it exactly which value the design compares. It then waits a random number of cycles before each sequence, so the second word falls both inside and outside the window. It also mixes in random wrong key words. The random delays are bounded by the counter value just read, so an expiry never hides the outcome being checked. Expiry and the lock after arming are driven with directed steps.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;
  localparam int KEY_W  = 16;
  localparam int RCT_W  = 4;
  localparam int WIN_W  = 8;
  localparam int ST_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_KEY    = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'hA0;
  localparam logic [ADDR_W-1:0] OFS_REACT  = 8'hA4;
  localparam logic [ADDR_W-1:0] OFS_WINDOW = 8'hA8;

  localparam logic [BUS_W-1:0] ARM_WORD  = 32'hA98559DA;
  localparam logic [KEY_W-1:0] SVC_FIRST = 16'hE51A;
  localparam logic [KEY_W-1:0] SVC_LAST  = 16'hA35C;
  localparam logic [RCT_W-1:0] REACT_NMI = 4'hA;
  localparam logic [RCT_W-1:0] REACT_RST = 4'h5;
  localparam logic [WIN_W-1:0] WIN_HALF  = 8'h50;
  localparam logic [WIN_W-1:0] WIN_FULL  = 8'h00;

  localparam int ST_EXPIRY = 0;
  localparam int ST_WINDOW = 1;
  localparam int ST_KEY    = 2;

  typedef struct packed {
    logic reload;
    logic count;
  } cntStrobe_t;

  typedef struct packed {
    logic atZero;
    logic windowOpen;
  } cntFlags_t;

  typedef enum logic {
    KEY_WAIT_FIRST = 1'b0,
    KEY_WAIT_LAST  = 1'b1
  } keyState_t;
endpackage

// File: rtl/kwd_dpath.sv
module kwd_dpath
  import kwd_pkg::*;
#(
  parameter int PRELOAD_W = 12,
  parameter int SHIFT     = 13,
  parameter int CNT_W     = PRELOAD_W + SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cntStrobe_t           strobe,
  input  logic [PRELOAD_W-1:0] preload,
  input  logic                 halfWindow,
  output logic [CNT_W-1:0]     cnt,
  output cntFlags_t            flags
);
  logic [CNT_W-1:0] scaledVal;
  logic [CNT_W-1:0] halfVal;

  assign scaledVal = CNT_W'(preload) << SHIFT;
  assign halfVal   = scaledVal >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.reload) begin
      cnt <= scaledVal;
    end else if (strobe.count) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign flags.atZero     = (cnt == '0);
  assign flags.windowOpen = halfWindow ? (cnt < halfVal) : 1'b1;

  // R3: a plain counting cycle lowers the value by exactly one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.count && !strobe.reload) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R5: a reload lands the scaled value seen at that edge
  p_reload_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (cnt == $past(scaledVal)));
endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int PRELOAD_W = 12,
  parameter int CNT_W     = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [BUS_W-1:0]     busWData,
  input  logic                 busWe,
  output logic [BUS_W-1:0]     busRData,
  input  logic [CNT_W-1:0]     cnt,
  input  cntFlags_t            flags,
  output cntStrobe_t           strobe,
  output logic [PRELOAD_W-1:0] preloadReg,
  output logic                 halfWindow,
  output logic                 nmiOut,
  output logic                 rstOut
);
  logic             armed;
  logic [RCT_W-1:0] reactReg;
  logic [WIN_W-1:0] winReg;
  logic [ST_W-1:0]  statusReg;
  keyState_t        keyState, keyNext;

  logic wrCtrl, wrReload, wrStatus, wrKey, wrReact, wrWindow;
  logic armNow, cfgOpen;
  logic keyWr, isFirst, isLast, keyViol, seqDone, svcOk, winViol, expiry, anyViol;
  logic [ST_W-1:0] stSet, stClr;

  assign wrCtrl   = busWe && (busAddr == OFS_CTRL);
  assign wrReload = busWe && (busAddr == OFS_RELOAD);
  assign wrStatus = busWe && (busAddr == OFS_STATUS);
  assign wrKey    = busWe && (busAddr == OFS_KEY);
  assign wrReact  = busWe && (busAddr == OFS_REACT);
  assign wrWindow = busWe && (busAddr == OFS_WINDOW);

  assign cfgOpen = !armed;
  assign armNow  = cfgOpen && wrCtrl && (busWData == ARM_WORD);

  // key sequence tracking
  assign keyWr   = wrKey && armed;
  assign isFirst = (busWData == BUS_W'(SVC_FIRST));
  assign isLast  = (busWData == BUS_W'(SVC_LAST));

  always_comb begin
    keyNext = keyState;
    keyViol = 1'b0;
    seqDone = 1'b0;
    if (keyWr) begin
      unique case (keyState)
        KEY_WAIT_FIRST: begin
          if (isFirst) keyNext = KEY_WAIT_LAST;
          else         keyViol = 1'b1;
        end
        KEY_WAIT_LAST: begin
          keyNext = KEY_WAIT_FIRST;
          if (isLast) seqDone = 1'b1;
          else        keyViol = 1'b1;
        end
        default: keyNext = KEY_WAIT_FIRST;
      endcase
    end
  end

  assign svcOk   = seqDone && flags.windowOpen;
  assign winViol = seqDone && !flags.windowOpen;
  assign expiry  = armed && flags.atZero;
  assign anyViol = expiry || winViol || keyViol;

  always_comb begin
    stSet = '0;
    stSet[ST_EXPIRY] = expiry;
    stSet[ST_WINDOW] = winViol;
    stSet[ST_KEY]    = keyViol;
    stClr = wrStatus ? busWData[ST_W-1:0] : '0;
  end

  assign strobe.reload = armNow || expiry || svcOk;
  assign strobe.count  = armed;
  assign halfWindow    = (winReg == WIN_HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      preloadReg <= '1;
      reactReg   <= REACT_RST;
      winReg     <= WIN_FULL;
      statusReg  <= '0;
      keyState   <= KEY_WAIT_FIRST;
      nmiOut     <= 1'b0;
      rstOut     <= 1'b0;
    end else begin
      if (armNow) armed <= 1'b1;
      if (cfgOpen && wrReload) preloadReg <= busWData[PRELOAD_W-1:0];
      if (cfgOpen && wrReact)  reactReg   <= busWData[RCT_W-1:0];
      if (cfgOpen && wrWindow) winReg     <= busWData[WIN_W-1:0];
      statusReg <= (statusReg & ~stClr) | stSet;
      keyState  <= keyNext;
      nmiOut    <= anyViol && (reactReg == REACT_NMI);
      rstOut    <= anyViol && (reactReg != REACT_NMI);
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_CTRL:   busRData = armed ? ARM_WORD : '0;
      OFS_RELOAD: busRData = BUS_W'(preloadReg);
      OFS_STATUS: busRData = BUS_W'(statusReg);
      OFS_COUNT:  busRData = BUS_W'(cnt);
      OFS_REACT:  busRData = BUS_W'(reactReg);
      OFS_WINDOW: busRData = BUS_W'(winReg);
      default:    busRData = '0;
    endcase
  end

  // R4: nothing but reset drops the armed state
  p_armed_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

  // R4: reload register frozen once armed
  p_cfg_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && wrReload) |=> $stable(preloadReg));

  // R8: zero count while armed raises the expiry flag and a pulse
  p_expiry_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && flags.atZero) |=> (statusReg[ST_EXPIRY] && (nmiOut || rstOut)));

  // R9: the two reaction outputs never fire together
  p_react_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nmiOut, rstOut}));

  // R11: an unarmed block stays quiet
  p_unarmed_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> (!nmiOut && !rstOut));
endmodule

// File: rtl/keyed_window_wdog.sv
module keyed_window_wdog
  import kwd_pkg::*;
#(
  parameter int PRELOAD_W     = 12,
  parameter int PRELOAD_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWData,
  input  logic              busWe,
  output logic [BUS_W-1:0]  busRData,
  output logic              nmiPulse,
  output logic              resetPulse
);
  localparam int CNT_W = PRELOAD_W + PRELOAD_SHIFT;

  cntStrobe_t           strobe;
  cntFlags_t            flags;
  logic [CNT_W-1:0]     cnt;
  logic [PRELOAD_W-1:0] preloadReg;
  logic                 halfWindow;

  kwd_ctrl #(.PRELOAD_W(PRELOAD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWData   (busWData),
    .busWe      (busWe),
    .busRData   (busRData),
    .cnt        (cnt),
    .flags      (flags),
    .strobe     (strobe),
    .preloadReg (preloadReg),
    .halfWindow (halfWindow),
    .nmiOut     (nmiPulse),
    .rstOut     (resetPulse)
  );

  kwd_dpath #(.PRELOAD_W(PRELOAD_W), .SHIFT(PRELOAD_SHIFT), .CNT_W(CNT_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .preload    (preloadReg),
    .halfWindow (halfWindow),
    .cnt        (cnt),
    .flags      (flags)
  );
endmodule

// File: tb/keyed_window_wdog_bench.sv
module keyed_window_wdog_bench;
  localparam int SH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWData = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRData;
  logic        nmiPulse, resetPulse;

  int nChecks = 0;
  int nFails  = 0;

  keyed_window_wdog #(.PRELOAD_W(12), .PRELOAD_SHIFT(SH)) u_keyed_window_wdog (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWData(busWData), .busWe(busWe),
    .busRData(busRData), .nmiPulse(nmiPulse), .resetPulse(resetPulse)
  );

  always #4 clk = ~clk;

  function automatic int scaled(int pre);
    return pre << SH;
  endfunction

  function automatic bit winOpen(int c, int pre, bit half);
    return half ? (c < (scaled(pre) >> 1)) : 1'b1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands at the next posedge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busAddr = a; busWe = 1'b0;
    #1 d = busRData;
  endtask

  task automatic pulses(string req, bit expNmi, bit expRst);
    chk({req, " nmi"}, {31'b0, nmiPulse}, {31'b0, expNmi});
    chk({req, " rst"}, {31'b0, resetPulse}, {31'b0, expRst});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c, c0, w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h90, v); chk("R1 ctrl", v, 0);
    rd(8'hA0, v); chk("R1 count", v, 0);
    rd(8'h98, v); chk("R1 status", v, 0);
    rd(8'h94, v); chk("R1 reload", v, 32'hFFF);
    rd(8'hA4, v); chk("R1 react", v, 5);
    rd(8'hA8, v); chk("R1 window", v, 0);
    pulses("R1", 0, 0);

    // R11 keys ignored while unarmed
    wr(8'h9C, 32'h1234); pulses("R11", 0, 0);
    wr(8'h9C, 32'hE51A); wr(8'h9C, 32'hA35C); pulses("R11", 0, 0);
    rd(8'h98, v); chk("R11 status", v, 0);

    // R2 wrong arming word
    wr(8'h90, 32'h12345678);
    rd(8'h90, v); chk("R2 no arm", v, 0);

    // configure and arm
    wr(8'h94, 8); wr(8'hA4, 32'hA); wr(8'hA8, 32'h50);
    wr(8'h90, 32'hA98559DA);
    rd(8'h90, v); chk("R2 armed", v, 32'hA98559DA);
    rd(8'hA0, v); chk("R3 load", v, scaled(8));
    repeat (5) @(negedge clk);
    rd(8'hA0, v); chk("R3 step", v, scaled(8) - 5);

    // R4 lock
    wr(8'h94, 3); wr(8'hA4, 5); wr(8'hA8, 0); wr(8'h90, 0);
    rd(8'h94, v); chk("R4 reload", v, 8);
    rd(8'hA4, v); chk("R4 react", v, 32'hA);
    rd(8'hA8, v); chk("R4 window", v, 32'h50);
    rd(8'h90, v); chk("R4 armed", v, 32'hA98559DA);

    // R6 window violation (counter high)
    wr(8'h9C, 32'hE51A);
    rd(8'hA0, v); c = int'(v);
    wr(8'h9C, 32'hA35C);
    pulses("R6/R9 window", 1, 0);
    rd(8'h98, v); chk("R6 status", v, 2);
    rd(8'hA0, v); chk("R6 no reload", v, c - 1);
    @(negedge clk); pulses("R9 one clock", 0, 0);

    // R10 clear
    wr(8'h98, 32'h0); rd(8'h98, v); chk("R10 zero write", v, 2);
    wr(8'h98, 32'h2); rd(8'h98, v); chk("R10 clear", v, 0);

    // R7 key violations
    wr(8'h9C, 32'hBEEF); pulses("R7 bad first", 1, 0);
    rd(8'h98, v); chk("R7 status", v, 4);
    wr(8'h9C, 32'hA35C); pulses("R7 restart", 1, 0);
    wr(8'h9C, 32'hE51A); pulses("R7 first ok", 0, 0);
    wr(8'h9C, 32'hE51A); pulses("R7 bad last", 1, 0);
    wr(8'h98, 32'h7);

    // R5 service inside window
    rd(8'hA0, v);
    while (int'(v) >= 60) begin @(negedge clk); rd(8'hA0, v); end
    wr(8'h9C, 32'hE51A); wr(8'h9C, 32'hA35C);
    pulses("R5 service", 0, 0);
    rd(8'hA0, v); chk("R5 reload", v, scaled(8));
    rd(8'h98, v); chk("R5 status", v, 0);

    // R8 expiry
    rd(8'hA0, v);
    while (v != 0) begin @(negedge clk); rd(8'hA0, v); end
    @(negedge clk);
    pulses("R8 expiry", 1, 0);
    rd(8'h98, v); chk("R8 status", v, 1);
    rd(8'hA0, v); chk("R8 reload", v, scaled(8));
    rd(8'h90, v); chk("R9 still armed", v, 32'hA98559DA);
    wr(8'h98, 32'h1);

    // random service timing around the window edge
    for (int it = 0; it < 150; it++) begin
      rd(8'hA0, v); c0 = int'(v);
      w = int'($urandom % (c0 - 5));
      repeat (w) @(negedge clk);
      if (($urandom % 5) == 0 && (c0 - w) > 12) begin
        logic [31:0] bad;
        bad = $urandom & 32'hFFFF;
        if (bad == 32'hE51A) bad = 32'h0;
        wr(8'h9C, bad);
        pulses("R7 random", 1, 0);
        rd(8'h98, v); chk("R7 random status", v, 4);
        wr(8'h98, 32'h4);
      end else begin
        wr(8'h9C, 32'hE51A);
        rd(8'hA0, v); c = int'(v);
        wr(8'h9C, 32'hA35C);
        if (winOpen(c, 8, 1'b1)) begin
          pulses("R5 random", 0, 0);
          rd(8'hA0, v); chk("R5 random reload", v, scaled(8));
        end else begin
          pulses("R6 random", 1, 0);
          rd(8'h98, v); chk("R6 random status", v, 2);
          rd(8'hA0, v); chk("R6 random count", v, c - 1);
          wr(8'h98, 32'h2);
        end
      end
    end

    // session two: reset disarms, reset reaction, full window
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(8'h90, v); chk("R4 reset disarms", v, 0);
    pulses("R1 after reset", 0, 0);
    wr(8'h94, 2);
    wr(8'h90, 32'hA98559DA);
    repeat (2) @(negedge clk);
    wr(8'h9C, 32'hE51A); wr(8'h9C, 32'hA35C);
    pulses("R6 full window", 0, 0);
    rd(8'hA0, v); chk("R6 full window reload", v, scaled(2));
    wr(8'h9C, 32'h0);
    pulses("R9 reset reaction", 0, 1);
    rd(8'h90, v); chk("R9 armed kept", v, 32'hA98559DA);
    @(negedge clk); pulses("R9 reset one clock", 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule